// File: doc/BRIEF.md
# Ring-Cascaded Queue Slice

This block is one slice of a deep first-in first-out queue assembled from several identical slices joined in a ring. Every slice sees the same write strobe, write data, read strobe and reset. Two tokens go round the ring: one grants the right to store, and the other grants the right to return a word. A slice stores the shared write word only while it holds the write token. It presents a word only while it holds the read token. When it has used its last storage location in either direction, it hands that token to the next slice with a one-cycle active-low pulse. The read outputs of all slices are ORed together, because a slice without the read token drives zero. The active-low full and empty flags of all slices are ANDed, so the composite flag is asserted whenever any slice asserts its flag.

The role of a slice is taken from its pins during reset. If either expansion-in pin is low, the slice runs alone as an ordinary queue. In that mode it has a half-full flag and a rewind input that returns the read position to location zero. If both expansion-in pins are high, the slice joins a ring. It is the head if its first-load/rewind pin is low, and a follower if that pin is high. In a ring, the half-full flag stays inactive and the shared pin only chooses the head.

All timing is synchronous to one clock. Reset is synchronous and active low.

Top module: `xq_slice`

## Requirements
- R1: While `rst_n` is low, the role is sampled on every clock. A low `xi_wr_n` or `xi_rd_n` selects alone. Both high with `fl_rt_n` low selects head. Both high with `fl_rt_n` high selects follower. After reset, a head or alone slice holds both tokens, and a follower holds neither.
- R2: Reset empties the slice and drives `xo_wr_n` and `xo_rd_n` high. It drives `full_n` and `half_n` high and `q` to zero. `empty_n` is low only in a slice that holds the read token.
- R3: A `wr` cycle is stored only by the slice that holds the write token, and only when that slice is not full. Writing the last location (index DEPTH-1) drives `xo_wr_n` low for exactly the next cycle. The next slice owns the write token from that cycle on.
- R4: Only the slice holding the read token presents a word on `q`; every other slice drives zero. A `rd` cycle removes that word. Reading the last location drives `xo_rd_n` low for exactly the next cycle and hands the read token on.
- R5: Across token hand-offs and ring wrap-around, the ORed `q` of the ring returns words in the order in which they were accepted.
- R6: `full_n` is low only when the slice holds the write token (always true when alone) and holds DEPTH words. A write while full is ignored, even if a read happens in the same cycle.
- R7: `empty_n` is low only when the slice holds the read token and holds no word. A read while empty is ignored. While empty, `q` is zero.
- R8: When alone, `half_n` is low exactly when the slice holds more than DEPTH/2 words.
- R9: When alone, a cycle with `fl_rt_n` low sets the read position to location zero. The word count becomes the write position, so the words from location zero up to the write position can be read again. `wr` and `rd` are ignored in that cycle.
- R10: In a ring, `half_n` stays high, and `fl_rt_n` has no effect after reset.
- R11: When alone, `xo_wr_n` and `xo_rd_n` stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; role sampled while low |
| wr | input | 1 | Shared write strobe |
| wdata | input | WIDTH | Shared write word |
| rd | input | 1 | Shared read strobe |
| q | output | WIDTH | Front word when holding read token and not empty, else zero |
| fl_rt_n | input | 1 | First-load select at reset; rewind when alone |
| xi_wr_n | input | 1 | Write-token pass from previous slice, active low |
| xi_rd_n | input | 1 | Read-token pass from previous slice, active low |
| xo_wr_n | output | 1 | Write-token pass to next slice, active low |
| xo_rd_n | output | 1 | Read-token pass to next slice, active low |
| full_n | output | 1 | Full flag, active low |
| empty_n | output | 1 | Empty flag, active low |
| half_n | output | 1 | More-than-half flag, active low, alone only |

## Verification
The hardest state to reach is a ring that is completely full, with the write token back on the slice that also holds the read token. It matters most when reads and writes hit the same cycle in that state, and when a token arrives at a slice in the very cycle it is needed. The bench first fills three four-word slices past capacity. It then drains them past empty. Next it runs a long stretch of random traffic with heavy writes, followed by one with heavy reads, so that both tokens circle the ring many times and meet at full and at empty. A behavioural queue predicts every slice's flags, pass pulses and output on every cycle. A separate lone slice is driven through half-full, rewind and overflow.

// File: rtl/xq_pkg.sv
package xq_pkg;
   typedef enum logic [1:0] {
      XQ_ALONE = 2'd0,
      XQ_HEAD  = 2'd1,
      XQ_TAIL  = 2'd2
   } xq_role_e;

   function automatic xq_role_e xq_decode(input logic xi_wr_n, input logic xi_rd_n,
                                          input logic fl_n);
      if (!(xi_wr_n && xi_rd_n)) return XQ_ALONE;
      return fl_n ? XQ_TAIL : XQ_HEAD;
   endfunction
endpackage

// File: rtl/xq_role_latch.sv
module xq_role_latch
   import xq_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     xi_wr_n,
   input  logic     xi_rd_n,
   input  logic     fl_rt_n,
   output xq_role_e role_nxt,
   output xq_role_e role
);
   assign role_nxt = xq_decode(xi_wr_n, xi_rd_n, fl_rt_n);

   always_ff @(posedge clk) begin
      if (!rst_n) role <= role_nxt;
   end
endmodule

// File: rtl/xq_token.sv
module xq_token (
   input  logic clk,
   input  logic rst_n,
   input  logic init,
   input  logic cascade,
   input  logic take_n,
   input  logic give,
   output logic own,
   output logic pass_n
);
   logic tok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tok    <= init;
         pass_n <= 1'b1;
      end else begin
         pass_n <= !(cascade && give);
         if (cascade) begin
            if (give)         tok <= 1'b0;
            else if (!take_n) tok <= 1'b1;
         end
      end
   end

   // A pass pulse grants ownership in the same cycle, so the ring never has a gap.
   assign own = cascade ? (tok | !take_n) : 1'b1;
endmodule

// File: rtl/xq_store.sv
module xq_store #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 16,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             rewind,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata,
   output logic             wlast,
   output logic             rlast,
   output logic [CW-1:0]    count
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (rewind) begin
         rptr  <= '0;
         count <= CW'(wptr);
      end else begin
         if (push) wptr <= bump(wptr);
         if (pop)  rptr <= bump(rptr);
         count <= count + CW'(push) - CW'(pop);
      end
   end

   assign rdata = mem[rptr];
   assign wlast = (wptr == AW'(DEPTH - 1));
   assign rlast = (rptr == AW'(DEPTH - 1));
endmodule

// File: rtl/xq_slice.sv
module xq_slice
   import xq_pkg::*;
#(
   parameter int WIDTH = 9,
   parameter int DEPTH = 16,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rd,
   output logic [WIDTH-1:0] q,
   input  logic             fl_rt_n,
   input  logic             xi_wr_n,
   input  logic             xi_rd_n,
   output logic             xo_wr_n,
   output logic             xo_rd_n,
   output logic             full_n,
   output logic             empty_n,
   output logic             half_n
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("xq_slice: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("xq_slice: WIDTH must be at least 1");
   end

   xq_role_e role, role_nxt;
   logic cascade, tok_init, rt, push, pop, full_i, empty_i, wlast, rlast;
   logic [1:0] take_n, give, own, pass_n;
   logic [WIDTH-1:0] rdata;
   logic [CW-1:0] count;

   xq_role_latch u_role (
      .clk(clk), .rst_n(rst_n), .xi_wr_n(xi_wr_n), .xi_rd_n(xi_rd_n),
      .fl_rt_n(fl_rt_n), .role_nxt(role_nxt), .role(role)
   );

   assign cascade  = (role != XQ_ALONE);
   assign tok_init = (role_nxt != XQ_TAIL);
   assign rt       = !cascade && !fl_rt_n;

   assign full_i  = (count == CW'(DEPTH));
   assign empty_i = (count == '0);
   assign push    = wr && own[0] && !full_i && !rt;
   assign pop     = rd && own[1] && !empty_i && !rt;

   assign take_n = {xi_rd_n, xi_wr_n};
   assign give   = {pop && rlast, push && wlast};

   for (genvar d = 0; d < 2; d++) begin : g_tok
      xq_token u_tok (
         .clk(clk), .rst_n(rst_n), .init(tok_init), .cascade(cascade),
         .take_n(take_n[d]), .give(give[d]), .own(own[d]), .pass_n(pass_n[d])
      );
   end

   xq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .rewind(rt),
      .wdata(wdata), .rdata(rdata), .wlast(wlast), .rlast(rlast), .count(count)
   );

   assign xo_wr_n = pass_n[0];
   assign xo_rd_n = pass_n[1];
   assign full_n  = !(own[0] && full_i);
   assign empty_n = !(own[1] && empty_i);
   assign half_n  = cascade ? 1'b1 : !(count > CW'(DEPTH / 2));
   assign q       = (own[1] && !empty_i) ? rdata : '0;
endmodule

// File: rtl/xq_slice_chk.sv
module xq_slice_chk #(
   parameter int WIDTH = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr,
   input logic             rd,
   input logic             fl_rt_n,
   input logic             cascade,
   input logic             xo_wr_n,
   input logic             xo_rd_n,
   input logic             full_n,
   input logic             empty_n,
   input logic             half_n,
   input logic [WIDTH-1:0] q
);
   AST_WR_PASS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !xo_wr_n |=> xo_wr_n); // R3
   AST_WR_PASS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !xo_wr_n |-> $past(wr)); // R3
   AST_RD_PASS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !xo_rd_n |=> xo_rd_n); // R4
   AST_RD_PASS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !xo_rd_n |-> $past(rd)); // R4
   AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_n |-> (q == '0)); // R7
   AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty_n && !wr && (cascade || fl_rt_n)) |=> !empty_n); // R7
   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_n && !rd && (cascade || fl_rt_n)) |=> !full_n); // R6
   AST_HALF_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      !half_n |-> (xo_wr_n && xo_rd_n)); // R11
endmodule

bind xq_slice xq_slice_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr(wr), .rd(rd), .fl_rt_n(fl_rt_n), .cascade(cascade),
   .xo_wr_n(xo_wr_n), .xo_rd_n(xo_rd_n), .full_n(full_n), .empty_n(empty_n),
   .half_n(half_n), .q(q)
);

// File: tb/xq_slice_tb.sv
`timescale 1ns/1ps
module xq_slice_tb;
   localparam int NS = 3;
   localparam int D  = 4;
   localparam int W  = 8;
   localparam int CAP = NS * D;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, c_wr, c_rd, sl_fl_n, s_wr, s_rd, rt_n;
   logic [W-1:0] c_wd, s_wd;
   logic [NS-1:0] xo_w, xo_r, fn, en, hn;
   logic [W-1:0] q_s [NS];
   logic [W-1:0] sq;
   logic s_xw, s_xr, s_fn, s_en, s_hn;

   for (genvar i = 0; i < NS; i++) begin : g_ring
      localparam int PREV = (i + NS - 1) % NS;
      xq_slice #(.WIDTH(W), .DEPTH(D)) u_dut (
         .clk(clk), .rst_n(rst_n), .wr(c_wr), .wdata(c_wd), .rd(c_rd), .q(q_s[i]),
         .fl_rt_n((i == 0) ? 1'b0 : sl_fl_n),
         .xi_wr_n(xo_w[PREV]), .xi_rd_n(xo_r[PREV]),
         .xo_wr_n(xo_w[i]), .xo_rd_n(xo_r[i]),
         .full_n(fn[i]), .empty_n(en[i]), .half_n(hn[i])
      );
   end

   xq_slice #(.WIDTH(W), .DEPTH(D)) u_solo (
      .clk(clk), .rst_n(rst_n), .wr(s_wr), .wdata(s_wd), .rd(s_rd), .q(sq),
      .fl_rt_n(rt_n), .xi_wr_n(1'b0), .xi_rd_n(1'b0),
      .xo_wr_n(s_xw), .xo_rd_n(s_xr), .full_n(s_fn), .empty_n(s_en), .half_n(s_hn)
   );

   int nchk = 0, nerr = 0;
   bit done = 1'b0;

   // ring reference
   int rq[$];
   int nw = 0, nr = 0, pws = 0, prs = 0;
   bit pw = 1'b0, pr = 1'b0;
   int dat = 0;
   // lone reference
   int smem [D];
   int swp = 0, srp = 0, scnt = 0, sdat = 100;

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      int wsl = (nw / D) % NS;
      int rsl = (nr / D) % NS;
      logic [W-1:0] qor = '0;
      for (int i = 0; i < NS; i++) begin
         qor |= q_s[i];
         chk($sformatf("R4 q of slice %0d", i), int'(q_s[i]),
             (i == rsl && rq.size() > 0) ? rq[0] : 0);
         chk($sformatf("R6 full_n slice %0d", i), int'(fn[i]),
             (rq.size() == CAP && i == wsl) ? 0 : 1);
         chk($sformatf("R7 empty_n slice %0d", i), int'(en[i]),
             (rq.size() == 0 && i == rsl) ? 0 : 1);
         chk($sformatf("R3 xo_wr_n slice %0d", i), int'(xo_w[i]),
             (pw && pws == i) ? 0 : 1);
         chk($sformatf("R4 xo_rd_n slice %0d", i), int'(xo_r[i]),
             (pr && prs == i) ? 0 : 1);
         chk($sformatf("R10 half_n slice %0d", i), int'(hn[i]), 1);
      end
      chk("R5 ring order", int'(qor), (rq.size() > 0) ? rq[0] : 0);
      chk("R6 composite full_n", int'(&fn), (rq.size() == CAP) ? 0 : 1);
      chk("R7 composite empty_n", int'(&en), (rq.size() == 0) ? 0 : 1);
      chk("R9 lone q", int'(sq), (scnt > 0) ? smem[srp] : 0);
      chk("R6 lone full_n", int'(s_fn), (scnt == D) ? 0 : 1);
      chk("R7 lone empty_n", int'(s_en), (scnt == 0) ? 0 : 1);
      chk("R8 lone half_n", int'(s_hn), (scnt > D / 2) ? 0 : 1);
      chk("R11 lone pass pins", int'({s_xw, s_xr}), 3);
   endtask

   task automatic cyc(input bit w, input bit r, input bit sw, input bit sr, input bit rt);
      bit dpush, dpop, spush, spop;
      c_wr = w; c_rd = r; s_wr = sw; s_rd = sr; rt_n = !rt;
      dat  = (dat % 255) + 1;
      sdat = (sdat % 255) + 1;
      c_wd = W'(dat); s_wd = W'(sdat);
      @(posedge clk);
      dpush = w && (rq.size() < CAP);
      dpop  = r && (rq.size() > 0);
      pw = 1'b0; pr = 1'b0;
      if (dpop) begin
         void'(rq.pop_front());
         pr = (nr % D == D - 1); prs = (nr / D) % NS; nr++;
      end
      if (dpush) begin
         rq.push_back(dat);
         pw = (nw % D == D - 1); pws = (nw / D) % NS; nw++;
      end
      if (rt) begin
         srp = 0; scnt = swp;
      end else begin
         spush = sw && (scnt < D);
         spop  = sr && (scnt > 0);
         if (spush) begin smem[swp] = sdat; swp = (swp + 1) % D; end
         if (spop)  srp = (srp + 1) % D;
         scnt = scnt + int'(spush) - int'(spop);
      end
      @(negedge clk);
      check_all();
   endtask

   initial begin
      rst_n = 1'b0; c_wr = 0; c_rd = 0; s_wr = 0; s_rd = 0; rt_n = 1'b1;
      sl_fl_n = 1'b1; c_wd = '0; s_wd = '0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // reset state and roles
      chk("R1 head holds read token", int'(en[0]), 0);
      chk("R1 follower 1 holds no token", int'({en[1], fn[1]}), 3);
      chk("R1 follower 2 holds no token", int'({en[2], fn[2]}), 3);
      chk("R1 lone slice is empty", int'(s_en), 0);
      chk("R2 pass pins high", int'({xo_w, xo_r}), 6'h3f);
      chk("R2 full and half high", int'({fn, hn, s_fn, s_hn}), 8'hff);
      chk("R2 q zero", int'(q_s[0] | q_s[1] | q_s[2] | sq), 0);
      check_all();
      // R6: fill ring past capacity
      for (int k = 0; k < CAP + 2; k++) cyc(1, 0, 0, 0, 0);
      // R6: read and write together while full
      cyc(1, 1, 0, 0, 0);
      // R7: drain past empty
      for (int k = 0; k < CAP + 2; k++) cyc(0, 1, 0, 0, 0);
      // R7: read and write together while empty
      cyc(1, 1, 0, 0, 0);
      // R5: write-heavy traffic, with a follower's pin toggled (R10)
      for (int k = 0; k < 700; k++) begin
         if (k == 300) sl_fl_n = 1'b0;
         if (k == 305) sl_fl_n = 1'b1;
         cyc($urandom_range(0, 99) < 65, $urandom_range(0, 99) < 45, 0, 0, 0);
      end
      // R5: read-heavy traffic
      for (int k = 0; k < 700; k++)
         cyc($urandom_range(0, 99) < 35, $urandom_range(0, 99) < 65, 0, 0, 0);
      // lone slice: R8 half-full
      for (int k = 0; k < 3; k++) cyc(0, 0, 1, 0, 0);
      chk("R8 lone half_n after three words", int'(s_hn), 0);
      cyc(0, 0, 0, 1, 0);
      cyc(0, 0, 0, 1, 0);
      // R9 rewind with strobes ignored
      cyc(0, 0, 1, 1, 1);
      chk("R9 lone count after rewind", int'(s_en), 1);
      for (int k = 0; k < 3; k++) cyc(0, 0, 0, 1, 0);
      // R6 lone overflow
      for (int k = 0; k < D + 2; k++) cyc(0, 0, 1, 0, 0);
      chk("R6 lone full", int'(s_fn), 0);
      for (int k = 0; k < D + 1; k++) cyc(0, 0, 0, 1, 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end
endmodule